// File: doc/BRIEF.md
# Dual-Organisation Static RAM Model

This block is a clocked, synthesizable behavioural model of a small static RAM. One storage array can be reached in two ways. In word organisation, each access is a 16-bit word with two independently strobed byte lanes. In byte organisation, each access is a single byte: a low-order select bit picks which half of the addressed word is used, and data moves on the low lane only. The bidirectional data pins are split into an input bus, an output bus and a per-lane output-enable vector. A testbench can therefore see exactly when each lane would be in high impedance.

Controller testbenches use the model as the target. They drive the usual asynchronous SRAM controls, two chip enables (active low and active high), an output enable, a write enable and two byte strobes, and then check read data and lane enables. A write is open while both chip enables and the write enable are active. It is committed on the clock edge at which that condition ends, using the data present at that edge. The model keeps its contents for any length of deselection. The depth is set by the address-width parameter.

Top module: `dosram_top`

## Requirements
- R1: While `ce1_n` is 1 or `ce2` is 0, `dout_en` is 2'b00, whatever the other controls are.
- R2: While `lb_n` and `ub_n` are both 1, the device counts as deselected: `dout_en` is 2'b00 and a write attempted in that state leaves the array unchanged.
- R3: While selected with `we_n` = 1 and `oe_n` = 1, `dout_en` is 2'b00.
- R4: A word-organisation read (`org_word` = 1, selected, `we_n` = 1, `oe_n` = 0) sets `dout_en[0]` = !`lb_n` and `dout_en[1]` = !`ub_n`. Lane 0 is `dout[7:0]` and lane 1 is `dout[15:8]`. Each enabled lane shows the stored byte of word `addr`, and each lane that is not enabled carries zero.
- R5: A word-organisation write stores `din[7:0]` only if `lb_n` = 0 and `din[15:8]` only if `ub_n` = 0. The level of `oe_n` has no effect on this.
- R6: A byte-organisation read (`org_word` = 0) returns the low half of word `addr` when `byte_sel` = 0 and the high half when `byte_sel` = 1. The byte appears on `dout[7:0]` with `dout_en` = 2'b01, and `dout[15:8]` is zero.
- R7: A byte-organisation write stores `din[7:0]` into the half selected by `byte_sel` and leaves the other half of the word unchanged.
- R8: A write is committed on the clock edge at which the write condition ends. The value stored is `din` at that edge. Values of `din` seen on earlier edges of the same write are discarded.
- R9: Each of the following ends a write and commits it: `we_n` rising, `ce1_n` rising, `ce2` falling, or both strobes going high.
- R10: Array contents are held unchanged across any number of deselected cycles.
- R11: While selected with `we_n` = 0, `dout_en` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset; clears write tracking only |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte-lane strobe, active low |
| ub_n | input | 1 | Upper byte-lane strobe, active low |
| org_word | input | 1 | 1 = 16-bit word organisation, 0 = byte organisation |
| byte_sel | input | 1 | Byte organisation: 0 = low half, 1 = high half |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data (input side of the data pins) |
| dout | output | 16 | Read data (output side of the data pins) |
| dout_en | output | 2 | Per-lane output drive; 0 = high impedance |

## Verification
Word writes and reads are tried with all four strobe combinations, so a swapped or merged lane enable shows up as a wrong byte or a wrong enable bit. Byte accesses go to both halves of words that were filled with distinct patterns, which separates a wrong half selection from a wrong lane. Writes are held open for several cycles while `din` changes, and each is closed by a different terminator. The stored value therefore shows both whether the terminating edge's data was used and whether each terminator commits. Random mixes of these accesses, with long deselected gaps, are compared against a bench model of the array.

// File: rtl/dosram_pkg.sv
package dosram_pkg;

    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef logic [LANE_W-1:0]    lane_t;
    typedef logic [NUM_LANES-1:0] lane_mask_t;
    typedef logic [WORD_W-1:0]    word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_HIZ   = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        lane_mask_t lanes;
        logic       byte_org;
        logic       half;
    } ctl_s;

    function automatic lane_mask_t half_mask(input logic half);
        lane_mask_t m;
        m = '0;
        m[half] = 1'b1;
        return m;
    endfunction

    function automatic word_t spread_byte(input lane_t b);
        word_t w;
        for (int i = 0; i < NUM_LANES; i++) begin
            w[i*LANE_W +: LANE_W] = b;
        end
        return w;
    endfunction

endpackage

// File: rtl/dosram_decode.sv
module dosram_decode
    import dosram_pkg::*;
(
    input  logic ce1_n,
    input  logic ce2,
    input  logic oe_n,
    input  logic we_n,
    input  logic lb_n,
    input  logic ub_n,
    input  logic org_word,
    input  logic byte_sel,
    output ctl_s ctl
);

    logic chip_on;
    logic any_lane;

    always_comb begin
        any_lane = !(lb_n && ub_n);
        chip_on  = !ce1_n && ce2 && any_lane;

        ctl          = '0;
        ctl.byte_org = !org_word;
        ctl.half     = byte_sel;

        if (!chip_on) begin
            ctl.op = OP_IDLE;
        end else if (!we_n) begin
            ctl.op = OP_WRITE;
        end else if (!oe_n) begin
            ctl.op = OP_READ;
        end else begin
            ctl.op = OP_HIZ;
        end

        if (org_word) begin
            ctl.lanes = {!ub_n, !lb_n};
        end else begin
            ctl.lanes = half_mask(byte_sel);
        end
    end

endmodule

// File: rtl/dosram_wr_track.sv
module dosram_wr_track
    import dosram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_s              ctl,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output lane_mask_t        commit_mask,
    output word_t             commit_data
);

    logic              open_q;
    logic              byte_q;
    logic [ADDR_W-1:0] addr_q;
    lane_mask_t        mask_q;
    logic              wr_now;

    assign wr_now = (ctl.op == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            byte_q <= 1'b0;
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            open_q <= wr_now;
            if (wr_now) begin
                byte_q <= ctl.byte_org;
                addr_q <= addr;
                mask_q <= ctl.lanes;
            end
        end
    end

    assign commit      = open_q && !wr_now;
    assign commit_addr = addr_q;
    assign commit_mask = commit ? mask_q : '0;
    assign commit_data = byte_q ? spread_byte(din[LANE_W-1:0]) : din;

endmodule

// File: rtl/dosram_array.sv
module dosram_array
    import dosram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  lane_mask_t        wr_mask,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/dosram_top.sv
module dosram_top
    import dosram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              org_word,
    input  logic              byte_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        dout_en
);

    ctl_s              ctl;
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    lane_mask_t        wr_mask;
    word_t             wr_data;
    word_t             rd_word;
    word_t             rd_shaped;
    lane_mask_t        lane_on;

    dosram_decode u_decode (
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .lb_n     (lb_n),
        .ub_n     (ub_n),
        .org_word (org_word),
        .byte_sel (byte_sel),
        .ctl      (ctl)
    );

    dosram_wr_track #(.ADDR_W(ADDR_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .addr        (addr),
        .din         (din),
        .commit      (wr_commit),
        .commit_addr (wr_addr),
        .commit_mask (wr_mask),
        .commit_data (wr_data)
    );

    dosram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_mask (wr_mask),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr   (addr),
        .rdata   (rd_word)
    );

    always_comb begin
        if (ctl.op != OP_READ) begin
            lane_on = '0;
        end else if (ctl.byte_org) begin
            lane_on = 2'b01;
        end else begin
            lane_on = ctl.lanes;
        end

        if (ctl.byte_org) begin
            rd_shaped = '0;
            rd_shaped[LANE_W-1:0] = rd_word[ctl.half*LANE_W +: LANE_W];
        end else begin
            rd_shaped = rd_word;
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_out
        assign dout[l*LANE_W +: LANE_W] = lane_on[l] ? rd_shaped[l*LANE_W +: LANE_W] : '0;
    end

    assign dout_en = lane_on;

endmodule

// File: rtl/dosram_checker.sv
module dosram_checker (
    input logic       clk,
    input logic       rst,
    input logic       ce1_n,
    input logic       ce2,
    input logic       oe_n,
    input logic       we_n,
    input logic       lb_n,
    input logic       ub_n,
    input logic       org_word,
    input logic [1:0] dout_en,
    input logic       wr_commit
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ce1_n || !ce2) |-> dout_en == 2'b00); // R1

    AST_STROBES_OFF: assert property (@(posedge clk) disable iff (rst)
        (lb_n && ub_n) |-> dout_en == 2'b00); // R2

    AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (we_n && oe_n) |-> dout_en == 2'b00); // R3

    AST_WORD_LANE_LO: assert property (@(posedge clk) disable iff (rst)
        (org_word && lb_n) |-> !dout_en[0]); // R4

    AST_WORD_LANE_HI: assert property (@(posedge clk) disable iff (rst)
        (org_word && ub_n) |-> !dout_en[1]); // R4

    AST_BYTE_HI_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!org_word) |-> !dout_en[1]); // R6

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!we_n) |-> dout_en == 2'b00); // R11

    AST_END_COMMITS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!ce1_n && ce2 && !(lb_n && ub_n) && !we_n)
         && (ce1_n || !ce2 || we_n || (lb_n && ub_n))) |-> wr_commit); // R9

    AST_COMMIT_AFTER_OPEN: assert property (@(posedge clk) disable iff (rst)
        (past_ok && wr_commit) |-> $past(!ce1_n && ce2 && !we_n)); // R8

endmodule

bind dosram_top dosram_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .lb_n      (lb_n),
    .ub_n      (ub_n),
    .org_word  (org_word),
    .dout_en   (dout_en),
    .wr_commit (wr_commit)
);

// File: tb/dosram_top_bench.sv
`timescale 1ns/1ps
module dosram_top_bench;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic          lb_n = 1'b0, ub_n = 1'b0, org_word = 1'b1, byte_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_en;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl [DEPTH];
    int unsigned seed_sink;

    always #2.5 clk = ~clk;

    dosram_top #(.ADDR_W(AW)) u_dosram_top (
        .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .org_word(org_word), .byte_sel(byte_sel),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        lb_n = 1'b0; ub_n = 1'b0;
    endtask

    function automatic logic [1:0] exp_en(input logic w, input logic lb, input logic ub);
        if (lb && ub) return 2'b00;
        return w ? {!ub, !lb} : 2'b01;
    endfunction

    function automatic logic [15:0] exp_data(input logic w, input logic [AW-1:0] a,
                                             input logic s, input logic lb, input logic ub);
        logic [1:0] e;
        logic [15:0] v;
        e = exp_en(w, lb, ub);
        if (w) v = mdl[a];
        else   v = {8'h00, s ? mdl[a][15:8] : mdl[a][7:0]};
        if (!e[0]) v[7:0]  = 8'h00;
        if (!e[1]) v[15:8] = 8'h00;
        return v;
    endfunction

    // term: 0 we_n rises, 1 ce1_n rises, 2 ce2 falls, 3 both strobes rise
    task automatic do_write(input logic w, input logic [AW-1:0] a, input logic s,
                            input logic lb, input logic ub, input int nhold,
                            input int term, input logic [15:0] last);
        @(negedge clk);
        org_word = w; addr = a; byte_sel = s; lb_n = lb; ub_n = ub;
        ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = 1'($urandom);
        din = 16'($urandom);
        for (int i = 0; i < nhold; i++) begin
            @(negedge clk);
            chk("R11 lanes off during write", {14'd0, dout_en}, 16'd0);
            din = 16'($urandom);
        end
        @(negedge clk);
        din = last;
        case (term)
            0: we_n = 1'b1;
            1: ce1_n = 1'b1;
            2: ce2 = 1'b0;
            default: begin lb_n = 1'b1; ub_n = 1'b1; end
        endcase
        if (!(lb && ub)) begin
            if (w) begin
                if (!lb) mdl[a][7:0]  = last[7:0];
                if (!ub) mdl[a][15:8] = last[15:8];
            end else if (s) begin
                mdl[a][15:8] = last[7:0];
            end else begin
                mdl[a][7:0] = last[7:0];
            end
        end
        @(negedge clk);
        go_idle();
    endtask

    task automatic do_read(input string req, input logic w, input logic [AW-1:0] a,
                           input logic s, input logic lb, input logic ub);
        @(negedge clk);
        org_word = w; addr = a; byte_sel = s; lb_n = lb; ub_n = ub;
        ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        #1;
        chk({req, " enable"}, {14'd0, dout_en}, {14'd0, exp_en(w, lb, ub)});
        chk({req, " data"}, dout, exp_data(w, a, s, lb, ub));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        seed_sink = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R1 reset state lanes off", {14'd0, dout_en}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset lanes off", {14'd0, dout_en}, 16'd0);

        for (int i = 0; i < DEPTH; i++) begin
            do_write(1'b1, AW'(i), 1'b0, 1'b0, 1'b0, 0, 0, 16'(i * 16'h0391 + 16'h1a2b));
        end

        // R4: each strobe pattern on a word read
        do_read("R4 both lanes", 1'b1, 6'd5, 1'b0, 1'b0, 1'b0);
        do_read("R4 low lane", 1'b1, 6'd5, 1'b0, 1'b0, 1'b1);
        do_read("R4 high lane", 1'b1, 6'd5, 1'b0, 1'b1, 1'b0);

        // R1 / R3: quiet states with oe_n low or high
        @(negedge clk);
        ce1_n = 1'b1; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #1 chk("R1 ce1_n high", {14'd0, dout_en}, 16'd0);
        ce1_n = 1'b0; ce2 = 1'b0;
        #1 chk("R1 ce2 low", {14'd0, dout_en}, 16'd0);
        ce2 = 1'b1; oe_n = 1'b1;
        #1 chk("R3 oe_n high", {14'd0, dout_en}, 16'd0);
        go_idle();

        // R2: strobes both high on a read and a write
        do_read("R2 strobes high read", 1'b1, 6'd7, 1'b0, 1'b1, 1'b1);
        do_write(1'b1, 6'd7, 1'b0, 1'b1, 1'b1, 2, 0, 16'hdead);
        do_read("R2 array unchanged", 1'b1, 6'd7, 1'b0, 1'b0, 1'b0);

        // R5: lane-masked word writes, oe_n random
        do_write(1'b1, 6'd9, 1'b0, 1'b0, 1'b1, 1, 0, 16'hbeef);
        do_read("R5 low-only write", 1'b1, 6'd9, 1'b0, 1'b0, 1'b0);
        do_write(1'b1, 6'd9, 1'b0, 1'b1, 1'b0, 1, 0, 16'h7c3e);
        do_read("R5 high-only write", 1'b1, 6'd9, 1'b0, 1'b0, 1'b0);

        // R6 / R7: byte organisation on both halves
        do_read("R6 byte low half", 1'b0, 6'd12, 1'b0, 1'b0, 1'b0);
        do_read("R6 byte high half", 1'b0, 6'd12, 1'b1, 1'b1, 1'b1 ^ 1'b1);
        do_write(1'b0, 6'd12, 1'b1, 1'b0, 1'b0, 0, 0, 16'h00a5);
        do_read("R7 byte write high half", 1'b1, 6'd12, 1'b0, 1'b0, 1'b0);
        do_write(1'b0, 6'd13, 1'b0, 1'b1, 1'b0, 0, 0, 16'h005a);
        do_read("R7 byte write low half", 1'b1, 6'd13, 1'b0, 1'b0, 1'b0);

        // R8: long write, only terminating-edge data kept
        do_write(1'b1, 6'd20, 1'b0, 1'b0, 1'b0, 4, 0, 16'h1357);
        do_read("R8 last data kept", 1'b1, 6'd20, 1'b0, 1'b0, 1'b0);

        // R9: every terminator commits
        for (int t = 0; t < 4; t++) begin
            do_write(1'b1, AW'(30 + t), 1'b0, 1'b0, 1'b0, 2, t, 16'(16'hc0d0 + t));
            do_read("R9 terminator commits", 1'b1, AW'(30 + t), 1'b0, 1'b0, 1'b0);
        end

        // R10: long deselection holds data
        go_idle();
        repeat (40) @(negedge clk);
        do_read("R10 hold across deselect", 1'b1, 6'd20, 1'b0, 1'b0, 1'b0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic w, s, lb, ub;
            logic [AW-1:0] a;
            w  = 1'($urandom);
            s  = 1'($urandom);
            lb = 1'($urandom);
            ub = 1'($urandom);
            a  = AW'($urandom);
            if (($urandom % 3) == 0) begin
                do_write(w, a, s, lb, ub, int'($urandom % 3), int'($urandom % 4), 16'($urandom));
            end else begin
                do_read(w ? "R4 random word read" : "R6 random byte read", w, a, s, lb, ub);
            end
            if (($urandom % 8) == 0) begin
                go_idle();
                repeat (int'($urandom % 10)) @(negedge clk);
            end
        end

        for (int i = 0; i < DEPTH; i++) begin
            do_read("R10 final sweep", 1'b1, AW'(i), 1'b0, 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule